// File: doc/BRIEF.md
# Serial Debug Burst Write Receiver

This block lives in the test-clock domain behind a TAP controller and takes in a burst write that a debug host sends over the shift-DR data stream. A first DR scan carries a command word. The command is decoded when Update-DR is seen. It names the word width (8, 16 or 32 bits), a start address and the number of words.

A second DR scan carries the payload. The receiver ignores all zeros up to a single start bit. It then collects each word least significant bit first and presents it on a parallel output with a one-cycle valid strobe and the word's address. After each word it returns a ready bit on TDO. Once the last word is in, the host shifts in the CRC it computed over the data bits. The receiver returns one bit that tells whether that CRC matches its own.

The CRC is kept in reflected form and shifted in the same direction as the data, so one shift per bit suffices. Update-DR or test-logic-reset ends any burst in progress.

Top module: `dbg_burst_wr_rx`

## Requirements
- R1: After reset the block waits for a command, tdo_o is 0, word_valid_o is 0, and no payload bit has any effect until a valid command has been latched.
- R2: The command is 53 bits, shifted in LSB first while sel_i and shift_i are high. From the MSB down it holds a top-level flag (bit 52, must be 0), a 4-bit opcode (bits 51:48), a 32-bit start address (bits 47:16) and a 16-bit word count (bits 15:0). The command is latched on update_i only while the block is idle. Opcodes 1, 2 and 3 select write bursts of 8, 16 and 32-bit words. Any other opcode, a set top-level flag (for example a 3-bit module-select word whose MSB is 1) and a word count of 0 are ignored.
- R3: In the payload scan, bits before the first 1 are ignored. The 1 itself is the start bit and is neither data nor CRC input.
- R4: Each word is assembled LSB first and shown zero-extended on word_o. word_valid_o is high for exactly one cycle, in the cycle after the edge that takes the word's last bit. addr_o then holds the start address plus the word index times the word size in bytes.
- R5: In the shift cycle right after a word's last bit, tdo_o is 1 (word accepted). The host bit taken in that cycle is discarded.
- R6: The CRC starts at 0xFFFFFFFF. For every data bit d it shifts right by one and is XORed with 0xEDB88320 when d XOR the old bit 0 is 1. Only data bits enter it.
- R7: After the last word's status cycle the host shifts in 32 CRC bits, LSB first. In the next shift cycle tdo_o is 1 exactly when they equal the computed CRC. All later shifts are ignored until update_i.
- R8: update_i during a burst (armed, receiving data, status, CRC or match cycle) returns the block to idle without latching a new command, so payload bits that follow produce no words.
- R9: Asserting rst_i at any time aborts the burst and restores the reset state.
- R10: Shift edges with sel_i low change nothing; the burst continues unaffected when sel_i returns.
- R11: A scan of all zeros (at least 5 bits) followed by update_i is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_i | input | 1 | Asynchronous test-logic-reset, active high |
| sel_i | input | 1 | Debug chain selected by the current instruction |
| capture_i | input | 1 | TAP in Capture-DR |
| shift_i | input | 1 | TAP in Shift-DR |
| update_i | input | 1 | TAP in Update-DR |
| tdi_i | input | 1 | Serial data from host |
| tdo_o | output | 1 | Serial status back to host |
| word_o | output | 32 | Received word, zero-extended |
| addr_o | output | 32 | Address of the word on word_o |
| word_valid_o | output | 1 | One-cycle strobe for word_o and addr_o |

## Verification
The assertions assume that the TAP drives at most one of capture_i, shift_i and update_i in a cycle. They also assume that update_i follows the end of a scan rather than falling inside one. The bench drives these strobes from separate tasks that each raise a single strobe for one cycle, so this assumption always holds. Selection is dropped only between shift cycles. The host CRC is built by a separate bench function from the payload bits.

// File: rtl/dbg_burst_wr_rx.sv
module dbg_burst_wr_rx #(
  parameter int CMD_W = 53,
  parameter int WORD_W = 32,
  parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic [WORD_W-1:0] word_o,
  output logic [31:0]       addr_o,
  output logic              word_valid_o
);
  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_DATA, S_STAT, S_CRC, S_MATCH, S_DONE} st_t;

  st_t               state;
  logic [CMD_W-1:0]  cmd;
  logic [1:0]        sz;
  logic [31:0]       addr;
  logic [15:0]       cnt;
  logic [5:0]        bitcnt;
  logic [WORD_W-1:0] data;
  logic [31:0]       crc, rx;

  wire        step   = sel_i && shift_i;
  wire        cmd_ok = !cmd[CMD_W-1] && cmd[CMD_W-2 -: 2] == 2'b00 &&
                       cmd[CMD_W-4 -: 2] != 2'b00 && cmd[15:0] != 16'd0;
  wire [5:0]  wlast  = (sz == 2'd1) ? 6'd7 : (sz == 2'd2) ? 6'd15 : 6'd31;
  wire [31:0] nbytes = (sz == 2'd1) ? 32'd1 : (sz == 2'd2) ? 32'd2 : 32'd4;
  wire [31:0] crc_nx = {1'b0, crc[31:1]} ^ ((tdi_i ^ crc[0]) ? CRC_POLY : 32'd0);
  wire [WORD_W-1:0] data_nx = {tdi_i, data[WORD_W-1:1]};

  assign tdo_o = (state == S_STAT) || (state == S_MATCH && rx == crc);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      state <= S_IDLE;
      cmd <= '0;
      sz <= 2'd0;
      addr <= '0;
      cnt <= '0;
      bitcnt <= '0;
      data <= '0;
      crc <= 32'hFFFFFFFF;
      rx <= '0;
      word_o <= '0;
      addr_o <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (update_i) begin
        state <= S_IDLE;
        if (state == S_IDLE && cmd_ok) begin
          state <= S_ARMED;
          sz <= cmd[CMD_W-4 -: 2];
          addr <= cmd[47:16];
          cnt <= cmd[15:0];
          crc <= 32'hFFFFFFFF;
        end
      end else if (sel_i && capture_i && state == S_IDLE) begin
        cmd <= '0;
      end else if (step) begin
        case (state)
          S_IDLE: cmd <= {tdi_i, cmd[CMD_W-1:1]};
          S_ARMED: if (tdi_i) begin
            state <= S_DATA;
            bitcnt <= '0;
          end
          S_DATA: begin
            data <= data_nx;
            crc <= crc_nx;
            bitcnt <= bitcnt + 6'd1;
            if (bitcnt == wlast) begin
              state <= S_STAT;
              word_valid_o <= 1'b1;
              word_o <= data_nx >> (6'd31 - wlast);
              addr_o <= addr;
              addr <= addr + nbytes;
              cnt <= cnt - 16'd1;
            end
          end
          S_STAT: begin
            bitcnt <= '0;
            state <= (cnt == 16'd0) ? S_CRC : S_DATA;
          end
          S_CRC: begin
            rx <= {tdi_i, rx[31:1]};
            bitcnt <= bitcnt + 6'd1;
            if (bitcnt == 6'd31) state <= S_MATCH;
          end
          S_MATCH: state <= S_DONE;
          default: ;
        endcase
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    state == S_IDLE |-> !tdo_o && !word_valid_o);
  p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    word_valid_o |=> !word_valid_o);
  p_status_bit_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    word_valid_o |-> tdo_o);
  p_crc_seed_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    state == S_ARMED |-> crc == 32'hFFFFFFFF);
  p_abort_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    update_i && state != S_IDLE |=> state == S_IDLE);
  p_desel_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !sel_i && !update_i |=> $stable(state) && $stable(crc));
endmodule

// File: tb/test_dbg_burst_wr_rx.sv
module test_dbg_burst_wr_rx;
  logic clk = 1'b0;
  logic rst, sel, cap, shf, upd, tdi;
  logic tdo, vld;
  logic [31:0] word, addr;
  int tests = 0, fails = 0;
  logic l_tdo, l_vld;
  logic [31:0] l_word, l_addr;
  logic seen;
  logic [31:0] pay [4];

  always #10 clk = ~clk;

  dbg_burst_wr_rx i_dbg_burst_wr_rx (
    .clk_i(clk), .rst_i(rst), .sel_i(sel), .capture_i(cap), .shift_i(shf),
    .update_i(upd), .tdi_i(tdi), .tdo_o(tdo), .word_o(word), .addr_o(addr),
    .word_valid_o(vld));

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic d);
    return (c >> 1) ^ ((d ^ c[0]) ? 32'hEDB88320 : 32'd0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    l_tdo = tdo; l_vld = vld; l_word = word; l_addr = addr;
    seen = seen | tdo | vld;
  endtask

  task automatic shift_bit(input logic b);
    cap = 0; upd = 0; shf = 1; tdi = b;
    tick();
    shf = 0;
  endtask

  task automatic do_update();
    shf = 0; cap = 0; upd = 1; tick(); upd = 0;
  endtask

  task automatic do_capture();
    shf = 0; upd = 0; cap = 1; tick(); cap = 0;
  endtask

  task automatic send_cmd(input logic [52:0] v, input int len);
    do_capture();
    for (int i = 0; i < len; i++) shift_bit(v[i]);
    do_update();
  endtask

  task automatic run_burst(input logic [1:0] sz, input logic [31:0] a, input int n,
                           input int zeros, input bit corrupt);
    int w = 4 << sz;
    int nb = 1 << (sz - 1);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] cv, m;
    m = (w == 32) ? 32'hFFFFFFFF : ((32'd1 << w) - 1);
    send_cmd({1'b0, 2'b00, sz, a, n[15:0]}, 53);
    do_capture();
    for (int i = 0; i < zeros; i++) shift_bit(1'b0);
    shift_bit(1'b1);
    chk("R3 no strobe at start bit", {31'd0, l_vld}, 32'd0);
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < w; b++) begin
        c = crc_step(c, pay[k][b]);
        shift_bit(pay[k][b]);
      end
      chk("R4 word_valid", {31'd0, l_vld}, 32'd1);
      chk("R4 word", l_word, pay[k] & m);
      chk("R4 addr", l_addr, a + k * nb);
      chk("R5 status bit", {31'd0, l_tdo}, 32'd1);
      shift_bit(1'b1);
      chk("R4 single strobe", {31'd0, l_vld}, 32'd0);
    end
    cv = corrupt ? (c ^ 32'h0000_0100) : c;
    for (int b = 0; b < 32; b++) shift_bit(cv[b]);
    chk("R7 R6 crc match bit", {31'd0, l_tdo}, {31'd0, !corrupt});
    shift_bit(1'b1);
    chk("R7 quiet after match", {31'd0, l_tdo}, 32'd0);
    do_update();
  endtask

  task automatic t_reset();
    chk("R1 tdo", {31'd0, tdo}, 32'd0);
    chk("R1 valid", {31'd0, vld}, 32'd0);
    seen = 0;
    do_capture();
    for (int i = 0; i < 12; i++) shift_bit(1'b1);
    chk("R1 no output without command", {31'd0, seen}, 32'd0);
    do_update();
  endtask

  task automatic t_bursts();
    pay[0] = 32'hA5; pay[1] = 32'h3C; pay[2] = 32'hFF;
    run_burst(2'd1, 32'h0000_1000, 3, 2, 0);
    pay[0] = 32'hBEEF; pay[1] = 32'h0001;
    run_burst(2'd2, 32'h8000_0002, 2, 0, 0);
    pay[0] = 32'hDEAD_BEEF; pay[1] = 32'h1234_5678;
    run_burst(2'd3, 32'hFFFF_FFF8, 2, 5, 1);
  endtask

  task automatic quiet_scan(input string req);
    seen = 0;
    do_capture();
    for (int i = 0; i < 20; i++) shift_bit(1'b1);
    chk(req, {31'd0, seen}, 32'd0);
    do_update();
  endtask

  task automatic t_ignored();
    send_cmd({1'b0, 4'd5, 32'h0, 16'd2}, 53);
    quiet_scan("R2 read opcode ignored");
    send_cmd({50'd0, 3'b110}, 3);
    quiet_scan("R2 module select ignored");
    send_cmd({1'b0, 4'd1, 32'h0, 16'd0}, 53);
    quiet_scan("R2 zero count ignored");
    send_cmd(53'd0, 5);
    quiet_scan("R11 nop scan");
  endtask

  task automatic t_abort();
    seen = 0;
    send_cmd({1'b0, 4'd1, 32'h40, 16'd4}, 53);
    do_capture();
    shift_bit(1'b1);
    for (int i = 0; i < 4; i++) shift_bit(1'b1);
    do_update();
    quiet_scan("R8 abort by update");
  endtask

  task automatic t_reset_abort();
    send_cmd({1'b0, 4'd1, 32'h40, 16'd2}, 53);
    do_capture();
    shift_bit(1'b1);
    shift_bit(1'b0);
    rst = 1; tick(); rst = 0;
    chk("R9 tdo after reset", {31'd0, tdo}, 32'd0);
    seen = 0;
    for (int i = 0; i < 20; i++) shift_bit(1'b1);
    chk("R9 burst dropped", {31'd0, seen}, 32'd0);
    do_update();
  endtask

  task automatic t_desel();
    logic [7:0] v = 8'h96;
    send_cmd({1'b0, 4'd1, 32'h10, 16'd1}, 53);
    do_capture();
    shift_bit(1'b1);
    for (int b = 0; b < 4; b++) shift_bit(v[b]);
    sel = 0;
    for (int b = 0; b < 6; b++) shift_bit(b[0]);
    sel = 1;
    for (int b = 4; b < 8; b++) shift_bit(v[b]);
    chk("R10 word intact", l_word, 32'h96);
    chk("R10 strobe", {31'd0, l_vld}, 32'd1);
    do_update();
  endtask

  initial begin
    #(20 * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; sel = 1; cap = 0; shf = 0; upd = 0; tdi = 0; seen = 0;
    repeat (2) @(posedge clk);
    #2 rst = 0;
    t_reset();
    t_bursts();
    t_ignored();
    t_abort();
    t_reset_abort();
    t_desel();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule